// File: doc/BRIEF.md
# Exclusive Cache Hierarchy Request Triage

This block sits in front of the coherence controller of a cache hierarchy with a split first level (an instruction array and a data array) and a shared second level that never holds a line also held by either first-level array. It looks at each processor request and picks exactly one event for the controller to run, together with the line address that event acts on.

Before the request itself can be served, the hierarchy may first need room or may need to undo a copy in the wrong first-level array. In those cases the block emits a move into the second level or an eviction from the second level, and leaves the request pending. It then emits nothing for one cycle so that the tag arrays can update, and looks at the same request again. The request is accepted only on the cycle in which its demand event is chosen.

Each array supplies three things: whether the line is present, whether a free way exists, and which address it would evict. For the second level, the free-way flag and the eviction choice are given twice. One pair is for the request address. The other pair is for the victim of the first-level array on the request's side.

Top module: `req_triage`

## Requirements
- R1: While reset is high and on the first cycle after it, `evt_valid` is 0.
- R2: If the line is present in the first-level array of the other side and the second level has a free way for the request address, the event is L1-to-L2 move (code 3) on the request address.
- R3: If the line is present in the other side's first-level array and the second level has no free way for it, the event is L2 replacement (code 6) on `l2_victim_req`.
- R4: If the line is present in its own side's first-level array, the demand event for the request kind is emitted on the request address.
- R5: If the line is absent from its own side's array, that array has a free way, and the second level holds the line, the event is L2-to-instruction-L1 (code 4) when `req_instr` is 1, and L2-to-data-L1 (code 5) when it is 0. Either way it acts on the request address.
- R6: If the line is absent from its own side's array, that array has a free way, and the second level lacks the line, the demand event is emitted on the request address.
- R7: If its own side's array has no free way, the block acts on that array's victim. It emits L1-to-L2 move (code 3) on the victim address when `l2_room_vic` is 1. Otherwise it emits L2 replacement (code 6) on `l2_victim_vic`.
- R8: The demand code follows the request kind. Kind 0 (load) gives code 0. Kind 1 (store) gives code 1. Kind 2 (instruction fetch) gives code 2. Kind 3 is treated as a load and gives code 0.
- R9: `req_ready` is 1 only in a cycle where a request is valid, is being evaluated, and resolves to a demand event (codes 0 to 2).
- R10: In the cycle that shows a non-demand event, no request is evaluated. `req_ready` is 0, and `evt_valid` is 0 on the next cycle. The same request is evaluated again in the cycle after that.
- R11: Event code and address appear at the outputs one clock after the evaluating cycle. A cycle with `req_valid` low yields `evt_valid` low on the next cycle.
- R12: Presence in the other side's first-level array takes priority over every condition on the request's own side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request pending |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | AW | Line address of the request |
| req_instr | input | 1 | 1 = instruction side, 0 = data side |
| req_kind | input | 2 | 0 load, 1 store, 2 instruction fetch, 3 treated as load |
| il1_hit | input | 1 | Line present in instruction L1 |
| il1_room | input | 1 | Instruction L1 has a free way for the line |
| il1_victim | input | AW | Instruction L1 eviction choice for the line |
| dl1_hit | input | 1 | Line present in data L1 |
| dl1_room | input | 1 | Data L1 has a free way for the line |
| dl1_victim | input | AW | Data L1 eviction choice for the line |
| l2_hit | input | 1 | Line present in L2 |
| l2_room_req | input | 1 | L2 has a free way for the request address |
| l2_victim_req | input | AW | L2 eviction choice for the request address |
| l2_room_vic | input | 1 | L2 has a free way for the own-side L1 victim |
| l2_victim_vic | input | AW | L2 eviction choice for the own-side L1 victim |
| evt_valid | output | 1 | Event present |
| evt_code | output | 3 | Event code (0 to 6) |
| evt_addr | output | AW | Line address the event acts on |

## Verification
Two branches can be true in the same cycle. The line can sit in the other side's first-level array while the request's own side is also full, or is also a hit. The bench drives both conditions together on each side. It expects the event from the other side's branch (R12) with that branch's address, not the own-side victim. During the random phase, every cycle is compared against a reference model that holds its own copy of the one-cycle pause. This also judges the cases where a pause after a non-demand event coincides with a change in the request inputs.

// File: rtl/triage_pkg.sv
`timescale 1ns/1ps
package triage_pkg;

    typedef enum logic [1:0] {
        RQ_LOAD   = 2'd0,
        RQ_STORE  = 2'd1,
        RQ_IFETCH = 2'd2,
        RQ_RSVD   = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        EV_LOAD      = 3'd0,
        EV_STORE     = 3'd1,
        EV_IFETCH    = 3'd2,
        EV_L1_TO_L2  = 3'd3,
        EV_L2_TO_L1I = 3'd4,
        EV_L2_TO_L1D = 3'd5,
        EV_L2_REPL   = 3'd6
    } evt_e;

    // flags of one first-level array, already steered to a side
    typedef struct packed {
        logic hit;
        logic room;
    } l1_flags_t;

    function automatic evt_e demand_of(input req_kind_e k);
        case (k)
            RQ_STORE:  return EV_STORE;
            RQ_IFETCH: return EV_IFETCH;
            default:   return EV_LOAD;
        endcase
    endfunction

    function automatic logic is_demand(input evt_e e);
        return (e == EV_LOAD) || (e == EV_STORE) || (e == EV_IFETCH);
    endfunction

endpackage

// File: rtl/triage_side_sel.sv
`timescale 1ns/1ps
module triage_side_sel
    import triage_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          is_instr,
    input  logic          il1_hit,
    input  logic          il1_room,
    input  logic [AW-1:0] il1_victim,
    input  logic          dl1_hit,
    input  logic          dl1_room,
    input  logic [AW-1:0] dl1_victim,
    output l1_flags_t     own,
    output logic [AW-1:0] own_victim,
    output logic          other_hit
);
    l1_flags_t i_flags;
    l1_flags_t d_flags;

    assign i_flags = '{hit: il1_hit, room: il1_room};
    assign d_flags = '{hit: dl1_hit, room: dl1_room};

    always_comb begin
        if (is_instr) begin
            own        = i_flags;
            own_victim = il1_victim;
            other_hit  = d_flags.hit;
        end else begin
            own        = d_flags;
            own_victim = dl1_victim;
            other_hit  = i_flags.hit;
        end
    end
endmodule

// File: rtl/triage_decide.sv
`timescale 1ns/1ps
module triage_decide
    import triage_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          is_instr,
    input  req_kind_e     kind,
    input  logic [AW-1:0] addr,
    input  l1_flags_t     own,
    input  logic [AW-1:0] own_victim,
    input  logic          other_hit,
    input  logic          l2_hit,
    input  logic          l2_room_req,
    input  logic [AW-1:0] l2_victim_req,
    input  logic          l2_room_vic,
    input  logic [AW-1:0] l2_victim_vic,
    output evt_e          evt,
    output logic [AW-1:0] evt_addr
);
    always_comb begin
        evt      = demand_of(kind);
        evt_addr = addr;
        if (other_hit) begin
            // wrong first-level copy must leave before anything else
            if (l2_room_req) begin
                evt      = EV_L1_TO_L2;
                evt_addr = addr;
            end else begin
                evt      = EV_L2_REPL;
                evt_addr = l2_victim_req;
            end
        end else if (own.hit) begin
            evt      = demand_of(kind);
            evt_addr = addr;
        end else if (own.room) begin
            if (l2_hit) begin
                evt      = is_instr ? EV_L2_TO_L1I : EV_L2_TO_L1D;
                evt_addr = addr;
            end else begin
                evt      = demand_of(kind);
                evt_addr = addr;
            end
        end else if (l2_room_vic) begin
            evt      = EV_L1_TO_L2;
            evt_addr = own_victim;
        end else begin
            evt      = EV_L2_REPL;
            evt_addr = l2_victim_vic;
        end
    end
endmodule

// File: rtl/triage_evt_reg.sv
`timescale 1ns/1ps
module triage_evt_reg
    import triage_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          eval,
    input  evt_e          evt_d,
    input  logic [AW-1:0] addr_d,
    output logic          valid_q,
    output evt_e          evt_q,
    output logic [AW-1:0] addr_q,
    output logic          hold_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            evt_q   <= EV_LOAD;
            addr_q  <= '0;
            hold_q  <= 1'b0;
        end else begin
            valid_q <= eval;
            hold_q  <= eval && !is_demand(evt_d);
            if (eval) begin
                evt_q  <= evt_d;
                addr_q <= addr_d;
            end
        end
    end
endmodule

// File: rtl/req_triage.sv
`timescale 1ns/1ps
module req_triage
    import triage_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_instr,
    input  logic [1:0]    req_kind,
    input  logic          il1_hit,
    input  logic          il1_room,
    input  logic [AW-1:0] il1_victim,
    input  logic          dl1_hit,
    input  logic          dl1_room,
    input  logic [AW-1:0] dl1_victim,
    input  logic          l2_hit,
    input  logic          l2_room_req,
    input  logic [AW-1:0] l2_victim_req,
    input  logic          l2_room_vic,
    input  logic [AW-1:0] l2_victim_vic,
    output logic          evt_valid,
    output logic [2:0]    evt_code,
    output logic [AW-1:0] evt_addr
);
    l1_flags_t     own;
    logic [AW-1:0] own_victim;
    logic          other_hit;
    evt_e          evt_d;
    evt_e          evt_q;
    logic [AW-1:0] addr_d;
    logic          hold_q;
    logic          eval;

    triage_side_sel #(.AW(AW)) u_sel (
        .is_instr   (req_instr),
        .il1_hit    (il1_hit),
        .il1_room   (il1_room),
        .il1_victim (il1_victim),
        .dl1_hit    (dl1_hit),
        .dl1_room   (dl1_room),
        .dl1_victim (dl1_victim),
        .own        (own),
        .own_victim (own_victim),
        .other_hit  (other_hit)
    );

    triage_decide #(.AW(AW)) u_dec (
        .is_instr      (req_instr),
        .kind          (req_kind_e'(req_kind)),
        .addr          (req_addr),
        .own           (own),
        .own_victim    (own_victim),
        .other_hit     (other_hit),
        .l2_hit        (l2_hit),
        .l2_room_req   (l2_room_req),
        .l2_victim_req (l2_victim_req),
        .l2_room_vic   (l2_room_vic),
        .l2_victim_vic (l2_victim_vic),
        .evt           (evt_d),
        .evt_addr      (addr_d)
    );

    // a cycle after a preparatory event is left idle for the arrays to settle
    assign eval      = req_valid && !hold_q;
    assign req_ready = eval && is_demand(evt_d);

    triage_evt_reg #(.AW(AW)) u_out (
        .clk     (clk),
        .rst     (rst),
        .eval    (eval),
        .evt_d   (evt_d),
        .addr_d  (addr_d),
        .valid_q (evt_valid),
        .evt_q   (evt_q),
        .addr_q  (evt_addr),
        .hold_q  (hold_q)
    );

    assign evt_code = evt_q;
endmodule

// File: rtl/triage_chk.sv
`timescale 1ns/1ps
module triage_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          evt_valid,
    input logic [2:0]    evt_code,
    input logic [AW-1:0] evt_addr
);
    // R9: acceptance only with a pending request
    a_r9_ready_needs_valid: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> req_valid);

    // R9: acceptance is followed by a demand event
    a_r9_ready_gives_demand: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> (evt_valid && evt_code < 3'd3));

    // R10: no acceptance while a preparatory event is showing
    a_r10_no_accept_in_pause: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_code >= 3'd3) |-> !req_ready);

    // R10: a preparatory event is followed by an empty cycle
    a_r10_gap_after_prep: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_code >= 3'd3) |=> !evt_valid);

    // R11: no request, no event next cycle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !evt_valid);

    // R11: code stays in the defined range
    a_r11_code_range: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> evt_code != 3'd7);
endmodule

bind req_triage triage_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .evt_addr  (evt_addr)
);

// File: tb/tb_req_triage.sv
`timescale 1ns/1ps
module tb_req_triage;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_ready, req_instr;
    logic [AW-1:0] req_addr;
    logic [1:0]    req_kind;
    logic          il1_hit, il1_room, dl1_hit, dl1_room;
    logic [AW-1:0] il1_victim, dl1_victim;
    logic          l2_hit, l2_room_req, l2_room_vic;
    logic [AW-1:0] l2_victim_req, l2_victim_vic;
    logic          evt_valid;
    logic [2:0]    evt_code;
    logic [AW-1:0] evt_addr;

    int total = 0;
    int bad   = 0;

    // reference state
    logic          m_hold = 1'b0;
    logic          m_v    = 1'b0;
    logic [2:0]    m_code = '0;
    logic [AW-1:0] m_addr = '0;
    string         m_tag  = "R1";

    always #4 clk = ~clk;

    req_triage #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_instr(req_instr), .req_kind(req_kind),
        .il1_hit(il1_hit), .il1_room(il1_room), .il1_victim(il1_victim),
        .dl1_hit(dl1_hit), .dl1_room(dl1_room), .dl1_victim(dl1_victim),
        .l2_hit(l2_hit), .l2_room_req(l2_room_req), .l2_victim_req(l2_victim_req),
        .l2_room_vic(l2_room_vic), .l2_victim_vic(l2_victim_vic),
        .evt_valid(evt_valid), .evt_code(evt_code), .evt_addr(evt_addr)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [2:0] want_demand(input logic [1:0] k);
        if (k == 2'd1) return 3'd1;   // store
        if (k == 2'd2) return 3'd2;   // instruction fetch
        return 3'd0;                  // load, and kind 3 as load
    endfunction

    // behavioural expectation, worded from the requirements
    task automatic ref_eval(output logic [2:0] c, output logic [AW-1:0] a,
                            output string tag);
        logic mine_hit, mine_room, theirs_hit;
        logic [AW-1:0] mine_vic;
        mine_hit   = req_instr ? il1_hit : dl1_hit;
        mine_room  = req_instr ? il1_room : dl1_room;
        mine_vic   = req_instr ? il1_victim : dl1_victim;
        theirs_hit = req_instr ? dl1_hit : il1_hit;
        if (theirs_hit && l2_room_req) begin
            c = 3; a = req_addr; tag = "R2/R12";
        end else if (theirs_hit) begin
            c = 6; a = l2_victim_req; tag = "R3/R12";
        end else if (mine_hit) begin
            c = want_demand(req_kind); a = req_addr; tag = "R4/R8";
        end else if (mine_room && l2_hit) begin
            c = req_instr ? 3'd4 : 3'd5; a = req_addr; tag = "R5";
        end else if (mine_room) begin
            c = want_demand(req_kind); a = req_addr; tag = "R6/R8";
        end else if (l2_room_vic) begin
            c = 3; a = mine_vic; tag = "R7";
        end else begin
            c = 6; a = l2_victim_vic; tag = "R7";
        end
    endtask

    task automatic cyc();
        logic [2:0] c;
        logic [AW-1:0] a;
        string t;
        logic ev, er;
        #1;
        ref_eval(c, a, t);
        ev = req_valid && !m_hold;
        er = ev && (c < 3);
        check(req_ready === er, er ? t : "R9/R10", "req_ready", req_ready, er);
        @(posedge clk);
        m_v    = ev;
        m_hold = ev && (c >= 3);
        if (ev) begin
            m_code = c; m_addr = a; m_tag = t;
        end else begin
            m_tag = req_valid ? "R10" : "R11";
        end
        @(negedge clk);
        check(evt_valid === m_v, m_tag, "evt_valid", evt_valid, m_v);
        if (m_v) begin
            check(evt_code === m_code, m_tag, "evt_code", evt_code, m_code);
            check(evt_addr === m_addr, m_tag, "evt_addr", evt_addr, m_addr);
        end
    endtask

    task automatic set_req(input logic v, input logic ins, input logic [1:0] k,
                           input logic ih, input logic ir, input logic dh,
                           input logic dr, input logic lh, input logic lrr,
                           input logic lrv);
        req_valid = v; req_instr = ins; req_kind = k;
        il1_hit = ih; il1_room = ir; dl1_hit = dh; dl1_room = dr;
        l2_hit = lh; l2_room_req = lrr; l2_room_vic = lrv;
        req_addr = 16'h1A40; il1_victim = 16'h2B00; dl1_victim = 16'h3C10;
        l2_victim_req = 16'h4D20; l2_victim_vic = 16'h5E30;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #1600000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        set_req(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(evt_valid === 1'b0, "R1", "evt_valid in reset", evt_valid, 0);
        end
        rst = 1'b0;
        // R1: first cycle after reset, idle
        cyc();
        // R4 R8: data side load and store hit
        set_req(1, 0, 0, 0, 1, 1, 1, 0, 1, 1); run(2);
        set_req(1, 0, 1, 0, 1, 1, 1, 0, 1, 1); run(2);
        // R4 R8: instruction fetch hit, kind 3 on data side
        set_req(1, 1, 2, 1, 1, 0, 1, 0, 1, 1); run(2);
        set_req(1, 0, 3, 0, 1, 1, 1, 0, 1, 1); run(2);
        // R2 R10: other-side presence, L2 has room; event, pause, again
        set_req(1, 0, 1, 1, 1, 0, 1, 0, 1, 1); run(5);
        // R3: other-side presence, L2 full
        set_req(1, 1, 2, 0, 1, 1, 1, 0, 0, 1); run(4);
        // R5: transfers into each side
        set_req(1, 1, 2, 0, 1, 0, 1, 1, 1, 1); run(3);
        set_req(1, 0, 0, 0, 1, 0, 1, 1, 1, 1); run(3);
        // R6: fetch from outside
        set_req(1, 0, 1, 0, 0, 0, 1, 0, 0, 0); run(2);
        // R7: own side full, victim moves to L2 or L2 evicts
        set_req(1, 0, 0, 0, 1, 0, 0, 0, 1, 1); run(3);
        set_req(1, 1, 2, 0, 0, 0, 1, 1, 1, 0); run(3);
        // R12: other-side presence with own side full and own side hit
        set_req(1, 0, 0, 1, 1, 0, 0, 0, 1, 0); run(3);
        set_req(1, 1, 2, 1, 1, 1, 1, 0, 0, 1); run(3);
        // R11: no request
        set_req(0, 0, 0, 1, 1, 1, 1, 1, 1, 1); run(3);
        // random phase against the model
        for (int i = 0; i < 3000; i++) begin
            req_valid     = ($urandom % 4) != 0;
            req_instr     = $urandom;
            req_kind      = $urandom;
            il1_hit       = ($urandom % 4) == 0;
            dl1_hit       = ($urandom % 4) == 0;
            il1_room      = $urandom;
            dl1_room      = $urandom;
            l2_hit        = $urandom;
            l2_room_req   = $urandom;
            l2_room_vic   = $urandom;
            req_addr      = AW'($urandom);
            il1_victim    = AW'($urandom);
            dl1_victim    = AW'($urandom);
            l2_victim_req = AW'($urandom);
            l2_victim_vic = AW'($urandom);
            cyc();
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule